// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block is the digital control half of a successive-approximation analog-to-digital converter. It owns one N-bit trial register whose value drives an external DAC. An external comparator reports back, one bit per clock, whether the sampled analog input is at or above the DAC level. The controller runs a binary search from the most significant bit down to the least. It keeps or drops each bit on that single comparator answer. After exactly N comparisons the same register holds the converted word.

The host pulses `start_i` while the block is idle. `busy_o` stays high for the N comparison cycles. `done_o` then pulses for one cycle, and `result_o` carries the code until the next conversion begins. As an example of scale, with an 8-bit word and a 5 V reference, one code step is the reference divided by 256, roughly 19.5 mV. The comparator, DAC and any sample-and-hold sit outside the block.

The control FSM has three states. IDLE waits for start. CONVERT makes one bit decision per clock. FINISH is the single done cycle. The transitions are:
- IDLE to CONVERT on `start_i`, which loads the first trial.
- CONVERT to CONVERT while bits remain.
- CONVERT to FINISH on the LSB decision.
- FINISH to IDLE unconditionally.
- IDLE to IDLE while no start is seen.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is held and right after it is released, `busy_o`, `done_o`, `dac_code_o` and `result_o` are all zero.
- R2: A `start_i` seen at a clock edge while idle makes `busy_o` high and `dac_code_o` equal to a word with only the MSB set (value 2^(N-1)) from the next cycle.
- R3: `cmp_above_i` high means the input is at or above the DAC level. At each comparison edge, the bit under test is kept when `cmp_above_i` is 1 and cleared when it is 0. The next lower bit is then set as the new trial. So trial k equals the accepted upper bits OR 2^k.
- R4: A conversion uses exactly N comparison cycles: `busy_o` is high for N consecutive cycles after the start edge.
- R5: `done_o` is high for exactly one cycle, the cycle right after the last busy cycle, and never appears without a conversion.
- R6: `start_i` is ignored while `busy_o` or `done_o` is high. The running conversion keeps its timing and result, and no new conversion begins after `done_o`.
- R7: The same register drives the DAC and forms the result. With an ideal comparator, `result_o` at `done_o` equals the input code, for every one of the 2^N codes.
- R8: While idle and without start, `dac_code_o` and `result_o` hold their value whatever `cmp_above_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, honoured only when idle |
| cmp_above_i | input | 1 | Comparator answer: 1 when the input is at or above the DAC level |
| dac_code_o | output | WIDTH | Trial code sent to the external DAC |
| result_o | output | WIDTH | Converted word, valid from `done_o` until the next start |
| busy_o | output | 1 | High during the comparison cycles |
| done_o | output | 1 | One-cycle pulse when the conversion ends |

## Verification
Taking the start edge as cycle 0, the first trial (MSB only) is due one cycle later. Trial k is due N-k cycles after start. `done_o` together with the final code is due N+1 cycles after start, and the block is idle again at N+2. The bench drives and samples on the falling edge and steps through these cycles one by one. A monitor counts the busy cycles and pops the expected code from a queue at each `done_o`, so a result that comes early, late or out of turn is flagged.

// File: rtl/sar_pkg.sv
package sar_pkg;

    // Control states of the conversion sequencer
    typedef enum logic [1:0] {
        SAR_IDLE    = 2'd0,
        SAR_CONVERT = 2'd1,
        SAR_FINISH  = 2'd2
    } sar_state_e;

endpackage

// File: rtl/sar_ctrl_fsm.sv
module sar_ctrl_fsm
    import sar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o
);

    sar_state_e state_q;
    sar_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SAR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SAR_IDLE: begin
                if (start_i) begin
                    state_d = SAR_CONVERT;
                end
            end
            SAR_CONVERT: begin
                if (last_i) begin
                    state_d = SAR_FINISH;
                end
            end
            SAR_FINISH: begin
                state_d = SAR_IDLE;
            end
            default: begin
                state_d = SAR_IDLE;
            end
        endcase
    end

    // Output logic
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            SAR_IDLE: begin
                load_o = start_i;
            end
            SAR_CONVERT: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            SAR_FINISH: begin
                done_o = 1'b1;
            end
            default: begin
                load_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             keep_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             last_o
);

    localparam logic [WIDTH-1:0] TOP_MASK = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] trial_q;   // trial word, also the result
    logic [WIDTH-1:0] probe_q;   // one-hot pointer to the bit under test
    logic [WIDTH-1:0] decided;
    logic [WIDTH-1:0] trial_d;

    // Keep or drop the bit under test, then raise the next lower bit
    always_comb begin
        decided = keep_i ? trial_q : (trial_q & ~probe_q);
        trial_d = decided | (probe_q >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            probe_q <= '0;
        end else if (load_i) begin
            trial_q <= TOP_MASK;
            probe_q <= TOP_MASK;
        end else if (step_i) begin
            trial_q <= trial_d;
            probe_q <= probe_q >> 1;
        end
    end

    assign trial_o = trial_q;
    assign last_o  = probe_q[0];

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_above_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic [WIDTH-1:0] result_o,
    output logic             busy_o,
    output logic             done_o
);

    logic load;
    logic step;
    logic last;
    logic [WIDTH-1:0] trial;

    sar_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .last_i  (last),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    sar_trial_reg #(
        .WIDTH (WIDTH)
    ) u_trial (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .keep_i  (cmp_above_i),
        .trial_o (trial),
        .last_o  (last)
    );

    // One register serves both the DAC and the output word
    assign dac_code_o = trial;
    assign result_o   = trial;

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             cmp_above_i,
    input logic [WIDTH-1:0] dac_code_o,
    input logic             busy_o,
    input logic             done_o
);

    localparam logic [WIDTH-1:0] TOP_MASK = {1'b1, {(WIDTH-1){1'b0}}};

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy_o) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |-> (!busy_o && !done_o && dac_code_o == '0));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> (busy_o && dac_code_o == TOP_MASK));

    // R3
    keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmp_above_i) |=> (dac_code_o >= $past(dac_code_o)));

    // R3
    drop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cmp_above_i) |=> (dac_code_o < $past(dac_code_o)));

    // R4
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_run == WIDTH));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));

    // R6
    start_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!busy_o && $stable(dac_code_o)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o && !start_i) |=> $stable(dac_code_o));

endmodule

bind sar_sequencer sar_sequencer_chk #(
    .WIDTH (WIDTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_above_i (cmp_above_i),
    .dac_code_o  (dac_code_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/sar_sequencer_tb_top.sv
`timescale 1ns/1ps
module sar_sequencer_tb_top;

    localparam int W    = 8;
    localparam int FULL = 1 << W;
    localparam int MSB  = 1 << (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    int           vin = 0;
    logic         cmp_above;
    logic [W-1:0] dac_code;
    logic [W-1:0] result;
    logic         busy;
    logic         done;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int busy_cycles = 0;
    int popped = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    // Ideal comparator: high when the input is at or above the DAC level
    assign cmp_above = (vin >= int'(dac_code));

    sar_sequencer #(.WIDTH(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .cmp_above_i (cmp_above),
        .dac_code_o  (dac_code),
        .result_o    (result),
        .busy_o      (busy),
        .done_o      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: busy length and scoreboard compare at each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cycles++;
            if (done) begin
                check(busy_cycles == W, "R4 busy cycles", busy_cycles, W);
                busy_cycles = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 done without conversion", int'(result), -1);
                end else begin
                    popped = exp_q.pop_front();
                    check(int'(result) == popped, "R7 result code", int'(result), popped);
                end
            end
        end
    end

    // Driver: one conversion, optional start pokes during busy and done
    task automatic convert(input int v, input bit poke_busy, input bit poke_done);
        @(negedge clk);
        vin = v;
        exp_q.push_back(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && int'(dac_code) == MSB, "R2 first trial", int'(dac_code), MSB);
        if (poke_busy) begin
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (poke_done) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(!busy && !done, "R6 start at done ignored", int'(busy), 0);
            check(int'(dac_code) == v, "R6 code held after done", int'(dac_code), v);
        end else begin
            @(negedge clk);
        end
    endtask

    // Step-by-step trial trace, R3
    task automatic trace(input int v);
        int acc = 0;
        @(negedge clk);
        vin = v;
        exp_q.push_back(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = W - 1; k >= 0; k--) begin
            int trial = acc | (1 << k);
            check(busy && int'(dac_code) == trial, "R3 trial value", int'(dac_code), trial);
            if (v >= trial) acc = trial;
            @(negedge clk);
        end
        check(done && int'(dac_code) == v, "R5 done with final code", int'(dac_code), v);
        @(negedge clk);
        check(!done && !busy, "R5 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && dac_code == '0 && result == '0, "R1 in reset", int'(dac_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && dac_code == '0 && result == '0, "R1 after reset", int'(result), 0);

        trace(8'hA5);
        trace(0);
        trace(FULL - 1);
        trace(MSB);

        // R8: idle with the comparator toggling
        for (int i = 0; i < 6; i++) begin
            vin = (i % 2 == 0) ? 0 : FULL - 1;
            @(negedge clk);
            check(int'(dac_code) == MSB && int'(result) == MSB && !busy && !done,
                  "R8 idle hold", int'(dac_code), MSB);
        end

        // R7 over every code, with R6 pokes mixed in
        for (int v = 0; v < FULL; v++) begin
            convert(v, (v % 7) == 3, (v % 5) == 1);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
        check(!busy && !done, "R6 no stray conversion", int'(busy), 0);
        finished = 1'b1;
        report();
    end

endmodule